// File: doc/BRIEF.md
# Command-Word MDIO Management Master

This block is a management-bus master for Ethernet PHYs. It is run entirely from one 32-bit command/status word. Software writes the word with the PHY address, the register address, the direction, the write data, an enable bit and a busy bit. The block then clocks out one IEEE 802.3 Clause 22 frame on MDC/MDIO and clears the busy bit when the frame ends. The same word can be read back at any time.

Software polls the word until busy reads 0. After a read, the low half of the word holds the 16 bits that the PHY returned. MDC is derived from the system clock by a half-period divider, `HALF_DIV`. The output data bit changes on the falling MDC edge, and the input is sampled on the rising edge. MDIO is split into three signals: the driven value, an output enable and the input value, so the pad-level tristate sits outside the block.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A write with bit 31 (busy) = 1 and bit 30 (enable) = 1 starts a frame, and `reg_rdata[31]` reads 1 from the next cycle. During the frame, MDC has exactly 64 rising edges. Busy stays high for exactly 128·`HALF_DIV` cycles and then reads 0.
- R3: A write with bit 30 = 0 starts no bus activity. `mdc` and `mdio_oe` stay low, and the word reads back as written with bit 31 forced to 0.
- R4: A write frame (bit 27 = 0), sampled at the MDC rising edges, is in this order: 32 ones, 01, opcode 01, PHY address from bits 25:21, register address from bits 20:16, turnaround 10, then data bits 15:0, with the MSB first in each field. `mdio_oe` is high for all 64 bits.
- R5: A read frame (bit 27 = 1) carries opcode 10. `mdio_oe` is high for the first 46 bits and low from the turnaround through the last data bit.
- R6: After a read frame, bits 15:0 of the word hold the 16 values of `mdio_i` sampled at the last 16 MDC rising edges, MSB first. Bits 30:16 are unchanged.
- R7: `mdio_o` and `mdio_oe` never change while `mdc` is high.
- R8: A write to the word while busy reads 1 is ignored. The frame in progress and the word contents are not disturbed.
- R9: With the default `HALF_DIV` = 16, a full frame completes within 2500 system cycles, which is 20 µs at 125 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the command/status word |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
Write frames are tried with all-zero and all-one addresses and data, and with random fields. These show whether each field lands in its own slot and whether the data is shifted MSB first. Read frames return random and alternating PHY data, which separates a correct capture from a shifted or bit-reversed one. Reads also confirm that the turnaround and the data bits are released. A command with the enable bit clear, and a second command written in the middle of a frame, check that neither one starts or disturbs bus activity.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int WORD_W     = 32;
    localparam int FRAME_BITS = 64;
    localparam int TA_START   = 46;
    localparam int DATA_START = 48;

    typedef struct packed {
        logic        busy;
        logic        en;
        logic [1:0]  spare_hi;
        logic        rd;
        logic        spare_lo;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(cmd_t c);
        logic [1:0] op;
        op = c.rd ? 2'b10 : 2'b01;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, 2'b10, c.data};
    endfunction
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
    parameter int HALF_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  cmd_t        cmd,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rd_data
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sh;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W-1:0]      nxt;
    logic                  is_rd;

    assign nxt    = idx + 1'b1;
    assign done   = fall_tick && (idx == LAST_IDX);
    assign mdio_o = sh[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            idx     <= '0;
            is_rd   <= 1'b0;
            mdio_oe <= 1'b0;
            rd_data <= '0;
        end else if (start) begin
            sh      <= build_frame(cmd);
            idx     <= '0;
            is_rd   <= cmd.rd;
            mdio_oe <= 1'b1;
        end else begin
            if (rise_tick && is_rd && (int'(idx) >= DATA_START))
                rd_data <= {rd_data[14:0], mdio_i};
            if (fall_tick) begin
                sh  <= sh << 1;
                idx <= nxt;
                if (idx == LAST_IDX)
                    mdio_oe <= 1'b0;
                else if (is_rd && (int'(nxt) >= TA_START))
                    mdio_oe <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    cmd_t        ctrl;
    cmd_t        wcmd;
    logic        accept;
    logic        start;
    logic        rise_tick;
    logic        fall_tick;
    logic        done;
    logic [15:0] rd_data;

    assign wcmd      = cmd_t'(reg_wdata);
    assign accept    = reg_wr && !ctrl.busy;
    assign start     = accept && wcmd.busy && wcmd.en;
    assign reg_rdata = ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (accept) begin
            ctrl      <= wcmd;
            ctrl.busy <= start;
        end else if (done) begin
            ctrl.busy <= 1'b0;
            if (ctrl.rd)
                ctrl.data <= rd_data;
        end
    end

    mdc_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd       (wcmd),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[31] |-> (!mdc && !mdio_oe));

    a_r7_change_on_low: assert property (@(posedge clk) disable iff (rst)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r8_word_frozen: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_rdata[31]) && reg_rdata[31]) |-> $stable(reg_rdata[30:0]));

    a_r6_fields_kept: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_rdata[31]) |-> (reg_rdata[30:16] == $past(reg_rdata[30:16])));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/sim_mdio_cmd_master.sv
module sim_mdio_cmd_master;
    localparam int HALF       = 16;
    localparam int FRAME_CLKS = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mdio_cmd_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic [31:0] c);
        return {32'hFFFF_FFFF, 2'b01, (c[27] ? 2'b10 : 2'b01),
                c[25:21], c[20:16], 2'b10, c[15:0]};
    endfunction

    function automatic logic phy_bit(input int r, input logic [15:0] w);
        if (r >= 48 && r < 64) return w[63 - r];
        return 1'b1;
    endfunction

    task automatic run_frame(input logic [31:0] cmd, input logic [15:0] rdw,
                             input int inj_at, input logic [31:0] inj_word,
                             output logic [63:0] bits, output logic [63:0] oeb,
                             output int busy_cyc, output int rises);
        logic prev;
        bits = '0; oeb = '0; busy_cyc = 0; rises = 0; prev = 1'b0;
        mdio_i = phy_bit(0, rdw);
        @(negedge clk);
        reg_wdata = cmd; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        while (reg_rdata[31] && busy_cyc < 5000) begin
            busy_cyc++;
            if (mdc && !prev && rises < 64) begin
                bits[63 - rises] = mdio_o;
                oeb[63 - rises]  = mdio_oe;
                rises++;
                mdio_i = phy_bit(rises, rdw);
            end
            prev = mdc;
            if (busy_cyc == inj_at) begin
                reg_wdata = inj_word; reg_wr = 1'b1;
            end else begin
                reg_wr = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
    endtask

    task automatic do_write(input logic [31:0] cmd, input string tag);
        logic [63:0] bits, oeb;
        int bc, rs;
        run_frame(cmd, 16'h0, -1, 32'h0, bits, oeb, bc, rs);
        chk(bits == exp_frame(cmd), "R4", {tag, " frame bits"}, bits, exp_frame(cmd));
        chk(oeb == '1, "R4", {tag, " oe"}, oeb, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(bc == FRAME_CLKS && rs == 64, "R2", {tag, " busy cycles"}, 64'(bc), 64'(FRAME_CLKS));
        chk(bc <= 2500, "R9", {tag, " within 20us"}, 64'(bc), 64'd2500);
        chk(reg_rdata == (cmd & 32'h7FFF_FFFF), "R2", {tag, " word after"},
            64'(reg_rdata), 64'(cmd & 32'h7FFF_FFFF));
    endtask

    task automatic do_read(input logic [31:0] cmd, input logic [15:0] rdw, input string tag);
        logic [63:0] bits, oeb, expb;
        logic [31:0] expw;
        int bc, rs;
        run_frame(cmd, rdw, -1, 32'h0, bits, oeb, bc, rs);
        expb = exp_frame(cmd);
        chk(bits[63:18] == expb[63:18], "R5", {tag, " header bits"}, 64'(bits[63:18]), 64'(expb[63:18]));
        chk(oeb == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5", {tag, " oe release"}, oeb,
            {46'h3FFF_FFFF_FFFF, 18'h0});
        expw = {1'b0, cmd[30:16], rdw};
        chk(reg_rdata == expw, "R6", {tag, " captured word"}, 64'(reg_rdata), 64'(expw));
        chk(bc == FRAME_CLKS, "R2", {tag, " busy cycles"}, 64'(bc), 64'(FRAME_CLKS));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] bits, oeb;
        int bc, rs;
        bit act;
        logic [31:0] c;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata == 0 && !mdc && !mdio_oe, "R1", "reset state",
            {reg_rdata, 30'h0, mdc, mdio_oe}, 64'h0);

        // R3 enable clear: nothing happens
        c = 32'h8FFF_1234 & ~32'h4000_0000;
        reg_wdata = c; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        act = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (mdc || mdio_oe) act = 1'b1;
            @(negedge clk);
        end
        chk(!act, "R3", "no bus activity", 64'(act), 64'h0);
        chk(reg_rdata == (c & 32'h7FFF_FFFF), "R3", "stored without busy",
            64'(reg_rdata), 64'(c & 32'h7FFF_FFFF));

        // R4 directed write corners
        do_write(32'hC000_0000, "zero");
        do_write(32'hC3FF_FFFF, "ones");
        do_write(32'hC2A5_8001, "mixed");
        for (int i = 0; i < 5; i++) begin
            c = ($urandom() & 32'h33FF_FFFF) | 32'hC000_0000;
            do_write(c, "rand");
        end

        // R5 / R6 directed and random reads
        do_read(32'hC800_0000 | (5 << 21) | (2 << 16), 16'hA5C3, "alt");
        do_read(32'hCBFF_0000, 16'h0001, "lsb");
        do_read(32'hC800_0000, 16'h8000, "msb");
        for (int i = 0; i < 5; i++) begin
            c = ($urandom() & 32'h33FF_FFFF) | 32'hC800_0000;
            do_read(c, 16'($urandom()), "rand");
        end

        // R8 write while busy is ignored
        c = 32'hC0C3_BEEF;
        run_frame(c, 16'h0, 700, 32'hC8FF_0000, bits, oeb, bc, rs);
        chk(bits == exp_frame(c), "R8", "frame undisturbed", bits, exp_frame(c));
        chk(bc == FRAME_CLKS, "R8", "busy length", 64'(bc), 64'(FRAME_CLKS));
        chk(reg_rdata == (c & 32'h7FFF_FFFF), "R8", "word undisturbed",
            64'(reg_rdata), 64'(c & 32'h7FFF_FFFF));

        // R7 is also covered by checker; confirm idle outputs after frames
        chk(!mdc && !mdio_oe, "R7", "idle after frames", {62'h0, mdc, mdio_oe}, 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule